// File: doc/BRIEF.md
# Dependent Load Preload Issue Window

This block holds early requests for loads whose base register is produced by an older load that is still outstanding. When such a load is dispatched, the block records one entry with the base value, the displacement, the load's own instruction ID and a tag that names the parent load. The base value is either the parent's address, or, when the parent is itself an early request, the parent's instruction ID, marked by a flag that says the base is not an address.

When the cache reports the hit or miss outcome of a parent, the block searches all entries at once. Entries waiting on a parent that missed become eligible to issue. Entries waiting on a parent that hit are discarded, since the ordinary load will find its data in the cache. Eligible entries leave, oldest first, through a registered ready/valid request port toward the memory controller. A pipeline flush removes every entry younger than the flush point. These requests occupy no miss-tracking resource, and the originating load still issues along its normal path later.

Top module: `pw_issue_window`

## Requirements
- R1: After reset, req_valid is 0 and drop_count is 0.
- R2: An inserted entry does not issue before its parent outcome; after a miss outcome (res_miss=1) whose res_tag equals the entry's parent tag is sampled at clock edge N, req_valid is 1 after edge N+1, with req_addr equal to the inserted base, req_disp and req_iid equal to the inserted values.
- R3: A hit outcome (res_miss=0) for the parent tag discards every entry waiting on it: no request is ever issued for them and their slots become free.
- R4: An outcome only affects entries whose parent tag equals res_tag; other waiting entries keep waiting and issue on their own parent's miss.
- R5: req_addr_valid is 1 when the entry was inserted with ins_base_is_id=0 and 0 when inserted with ins_base_is_id=1, in which case req_addr carries the parent ID given in ins_base.
- R6: The window holds ENTRIES (default 8) entries; an insertion while all are occupied is discarded and drop_count increases by exactly one (saturating at its maximum).
- R7: When several entries are eligible, they issue one per handshake in insertion order, oldest first, regardless of slot position.
- R8: While req_valid is 1 and req_ready is 0, the request stays valid and unchanged unless a flush removes it.
- R9: A flush removes every stored and every pending-output entry whose instruction ID is greater (unsigned) than flush_iid; entries with ID less than or equal to flush_iid remain and still issue.
- R10: An insertion in the same cycle as flush_valid is ignored and does not change drop_count.
- R11: An outcome broadcast in the same cycle as an insertion does not apply to the newly inserted entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | Insert a new entry this cycle |
| ins_base_is_id | input | 1 | 1: ins_base holds a parent instruction ID, not an address |
| ins_base | input | ADDR_W | Parent address or parent ID |
| ins_disp | input | DISP_W | Displacement added to the base |
| ins_iid | input | IID_W | Instruction ID of the dependent load |
| ins_ptag | input | TAG_W | Tag of the parent load whose outcome is awaited |
| res_valid | input | 1 | Parent outcome broadcast valid |
| res_tag | input | TAG_W | Tag of the parent whose outcome is known |
| res_miss | input | 1 | 1: parent missed, 0: parent hit |
| flush_valid | input | 1 | Pipeline flush |
| flush_iid | input | IID_W | Entries with larger instruction ID are removed |
| req_valid | output | 1 | Request to memory controller valid |
| req_ready | input | 1 | Memory controller accepts the request |
| req_addr_valid | output | 1 | req_addr is an address (1) or a parent ID (0) |
| req_addr | output | ADDR_W | Base address or parent ID |
| req_disp | output | DISP_W | Displacement |
| req_iid | output | IID_W | Instruction ID of the dependent load |
| drop_count | output | CNT_W | Number of insertions discarded because the window was full |

## Verification
The hardest case to reach is issue order that differs from slot order: with a fully empty window the oldest entry always sits in the lowest slot, so position and age agree. The stimulus releases and drains a middle entry first, refills the hole with a newer load, and only then releases the remaining entries together, so that an age-based choice and an index-based choice give different sequences. Flush timing is the other delicate point; a flush is applied in exactly the cycle that the first eligible entry moves to the output register, and separately while a request sits unaccepted at the port.

// File: rtl/pw_pkg.sv
package pw_pkg;
  typedef enum logic [1:0] {
    SLOT_FREE  = 2'd0,
    SLOT_WAIT  = 2'd1,
    SLOT_READY = 2'd2
  } slot_state_t;
endpackage

// File: rtl/pw_slot.sv
module pw_slot
  import pw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 16,
  parameter int IID_W  = 8,
  parameter int TAG_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alloc,
  input  logic              in_is_id,
  input  logic [ADDR_W-1:0] in_base,
  input  logic [DISP_W-1:0] in_disp,
  input  logic [IID_W-1:0]  in_iid,
  input  logic [TAG_W-1:0]  in_ptag,
  input  logic              res_valid,
  input  logic [TAG_W-1:0]  res_tag,
  input  logic              res_miss,
  input  logic              flush_valid,
  input  logic [IID_W-1:0]  flush_iid,
  input  logic              take,
  output slot_state_t       st,
  output logic              is_id,
  output logic [ADDR_W-1:0] base,
  output logic [DISP_W-1:0] disp,
  output logic [IID_W-1:0]  iid,
  output logic              killed
);
  logic [TAG_W-1:0] ptag;
  logic             tag_hit;

  assign killed  = (st != SLOT_FREE) && flush_valid && (iid > flush_iid);
  assign tag_hit = res_valid && (ptag == res_tag);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= SLOT_FREE;
    end else if (alloc) begin
      st <= SLOT_WAIT;
    end else if (killed || take) begin
      st <= SLOT_FREE;
    end else if (st == SLOT_WAIT && tag_hit) begin
      st <= res_miss ? SLOT_READY : SLOT_FREE;
    end
  end

  always_ff @(posedge clk) begin
    if (alloc) begin
      is_id <= in_is_id;
      base  <= in_base;
      disp  <= in_disp;
      iid   <= in_iid;
      ptag  <= in_ptag;
    end
  end
endmodule

// File: rtl/pw_age_matrix.sv
module pw_age_matrix #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] alloc,
  input  logic [N-1:0] ready,
  output logic [N-1:0] grant
);
  // older_q[i][j] = 1 when slot i was filled before slot j
  logic [N-1:0] older_q [N];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) older_q[i] <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        for (int j = 0; j < N; j++) begin
          if (alloc[i])      older_q[i][j] <= 1'b0;
          else if (alloc[j]) older_q[i][j] <= 1'b1;
        end
      end
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_grant
    logic [N-1:0] beaten;
    always_comb begin
      for (int j = 0; j < N; j++) beaten[j] = ready[j] && older_q[j][g];
    end
    assign grant[g] = ready[g] && !(|beaten);
  end
endmodule

// File: rtl/pw_issue_window.sv
module pw_issue_window
  import pw_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 32,
  parameter int DISP_W  = 16,
  parameter int IID_W   = 8,
  parameter int TAG_W   = 6,
  parameter int CNT_W   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ins_valid,
  input  logic              ins_base_is_id,
  input  logic [ADDR_W-1:0] ins_base,
  input  logic [DISP_W-1:0] ins_disp,
  input  logic [IID_W-1:0]  ins_iid,
  input  logic [TAG_W-1:0]  ins_ptag,
  input  logic              res_valid,
  input  logic [TAG_W-1:0]  res_tag,
  input  logic              res_miss,
  input  logic              flush_valid,
  input  logic [IID_W-1:0]  flush_iid,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_addr_valid,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DISP_W-1:0] req_disp,
  output logic [IID_W-1:0]  req_iid,
  output logic [CNT_W-1:0]  drop_count
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  slot_state_t       st     [ENTRIES];
  logic              s_isid [ENTRIES];
  logic [ADDR_W-1:0] s_base [ENTRIES];
  logic [DISP_W-1:0] s_disp [ENTRIES];
  logic [IID_W-1:0]  s_iid  [ENTRIES];
  logic [ENTRIES-1:0] killed, ready_vec, grant, alloc, take;

  logic             any_free;
  logic [IDX_W-1:0] free_idx;
  logic             do_ins, do_drop;
  logic             out_killed, load_out;

  // lowest free slot
  always_comb begin
    any_free = 1'b0;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (st[i] == SLOT_FREE) begin
        any_free = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end

  assign do_ins  = ins_valid && !flush_valid && any_free;
  assign do_drop = ins_valid && !flush_valid && !any_free;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    assign alloc[g]     = do_ins && (free_idx == IDX_W'(g));
    assign ready_vec[g] = (st[g] == SLOT_READY) && !killed[g];
    assign take[g]      = grant[g] && load_out;

    pw_slot #(
      .ADDR_W(ADDR_W), .DISP_W(DISP_W), .IID_W(IID_W), .TAG_W(TAG_W)
    ) u_slot (
      .clk        (clk),
      .rst        (rst),
      .alloc      (alloc[g]),
      .in_is_id   (ins_base_is_id),
      .in_base    (ins_base),
      .in_disp    (ins_disp),
      .in_iid     (ins_iid),
      .in_ptag    (ins_ptag),
      .res_valid  (res_valid),
      .res_tag    (res_tag),
      .res_miss   (res_miss),
      .flush_valid(flush_valid),
      .flush_iid  (flush_iid),
      .take       (take[g]),
      .st         (st[g]),
      .is_id      (s_isid[g]),
      .base       (s_base[g]),
      .disp       (s_disp[g]),
      .iid        (s_iid[g]),
      .killed     (killed[g])
    );
  end

  pw_age_matrix #(.N(ENTRIES)) u_age (
    .clk  (clk),
    .rst  (rst),
    .alloc(alloc),
    .ready(ready_vec),
    .grant(grant)
  );

  // selected entry fields
  logic              pick_isid;
  logic [ADDR_W-1:0] pick_base;
  logic [DISP_W-1:0] pick_disp;
  logic [IID_W-1:0]  pick_iid;

  always_comb begin
    pick_isid = 1'b0;
    pick_base = '0;
    pick_disp = '0;
    pick_iid  = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (grant[i]) begin
        pick_isid = pick_isid | s_isid[i];
        pick_base = pick_base | s_base[i];
        pick_disp = pick_disp | s_disp[i];
        pick_iid  = pick_iid  | s_iid[i];
      end
    end
  end

  assign out_killed = req_valid && flush_valid && (req_iid > flush_iid);
  assign load_out   = (|ready_vec) && (!req_valid || req_ready || out_killed);

  always_ff @(posedge clk) begin
    if (rst) begin
      req_valid <= 1'b0;
    end else if (load_out) begin
      req_valid <= 1'b1;
    end else if (out_killed || req_ready) begin
      req_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (load_out) begin
      req_addr_valid <= !pick_isid;
      req_addr       <= pick_base;
      req_disp       <= pick_disp;
      req_iid        <= pick_iid;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      drop_count <= '0;
    end else if (do_drop && (drop_count != {CNT_W{1'b1}})) begin
      drop_count <= drop_count + 1'b1;
    end
  end
endmodule

// File: rtl/pw_issue_window_chk.sv
module pw_issue_window_chk #(
  parameter int IID_W = 8,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             ins_valid,
  input logic             flush_valid,
  input logic [IID_W-1:0] flush_iid,
  input logic             req_valid,
  input logic             req_ready,
  input logic [IID_W-1:0] req_iid,
  input logic [CNT_W-1:0] drop_count
);
  logic out_flushed;
  assign out_flushed = req_valid && flush_valid && (req_iid > flush_iid);

  // R1
  a_r1_reset_idle: assert property (@(posedge clk)
    $past(rst) |-> (!req_valid && drop_count == '0));

  // R8
  a_r8_hold_request: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready && !out_flushed) |=> (req_valid && $stable(req_iid)));

  // R6
  a_r6_drop_step: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((drop_count == $past(drop_count)) ||
              (drop_count == CNT_W'($past(drop_count) + 1'b1))));

  // R10
  a_r10_flush_no_drop: assert property (@(posedge clk) disable iff (rst)
    flush_valid |=> $stable(drop_count));

  // R9
  a_r9_flush_output: assert property (@(posedge clk) disable iff (rst)
    out_flushed |=> (!req_valid || req_iid <= $past(flush_iid)));

  // R6: no count change without an insertion attempt
  a_r6_drop_needs_insert: assert property (@(posedge clk) disable iff (rst)
    !ins_valid |=> $stable(drop_count));
endmodule

bind pw_issue_window pw_issue_window_chk #(.IID_W(IID_W), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .ins_valid  (ins_valid),
  .flush_valid(flush_valid),
  .flush_iid  (flush_iid),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_iid    (req_iid),
  .drop_count (drop_count)
);

// File: tb/tb_pw_issue_window.sv
module tb_pw_issue_window;
  localparam int ADDR_W = 32, DISP_W = 16, IID_W = 8, TAG_W = 6, CNT_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ins_valid = 0, ins_base_is_id = 0;
  logic [ADDR_W-1:0] ins_base = '0;
  logic [DISP_W-1:0] ins_disp = '0;
  logic [IID_W-1:0]  ins_iid = '0;
  logic [TAG_W-1:0]  ins_ptag = '0;
  logic res_valid = 0, res_miss = 0;
  logic [TAG_W-1:0] res_tag = '0;
  logic flush_valid = 0;
  logic [IID_W-1:0] flush_iid = '0;
  logic req_valid, req_ready = 0, req_addr_valid;
  logic [ADDR_W-1:0] req_addr;
  logic [DISP_W-1:0] req_disp;
  logic [IID_W-1:0]  req_iid;
  logic [CNT_W-1:0]  drop_count;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pw_issue_window dut (
    .clk(clk), .rst(rst),
    .ins_valid(ins_valid), .ins_base_is_id(ins_base_is_id), .ins_base(ins_base),
    .ins_disp(ins_disp), .ins_iid(ins_iid), .ins_ptag(ins_ptag),
    .res_valid(res_valid), .res_tag(res_tag), .res_miss(res_miss),
    .flush_valid(flush_valid), .flush_iid(flush_iid),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr_valid(req_addr_valid),
    .req_addr(req_addr), .req_disp(req_disp), .req_iid(req_iid),
    .drop_count(drop_count)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic insert(input logic isid, input logic [ADDR_W-1:0] b,
                        input logic [DISP_W-1:0] d, input logic [IID_W-1:0] id,
                        input logic [TAG_W-1:0] pt);
    ins_valid = 1; ins_base_is_id = isid; ins_base = b; ins_disp = d;
    ins_iid = id; ins_ptag = pt;
    step();
    ins_valid = 0;
  endtask

  task automatic bcast(input logic [TAG_W-1:0] t, input logic miss);
    res_valid = 1; res_tag = t; res_miss = miss;
    step();
    res_valid = 0;
  endtask

  task automatic pop();
    req_ready = 1;
    step();
    req_ready = 0;
  endtask

  task automatic expect_req(input string tag, input logic [IID_W-1:0] id);
    chk({tag, " valid"}, req_valid, 1);
    chk({tag, " iid"}, req_iid, id);
  endtask

  task automatic t_reset();
    chk("R1 req_valid", req_valid, 0);
    chk("R1 drop_count", drop_count, 0);
  endtask

  task automatic t_miss();
    insert(0, 32'h1000, 16'h10, 8'd5, 6'd3);
    step();
    chk("R2 no issue before outcome", req_valid, 0);
    bcast(6'd3, 1);
    chk("R2 not yet after one edge", req_valid, 0);
    step();
    expect_req("R2", 8'd5);
    chk("R2 addr", req_addr, 32'h1000);
    chk("R2 disp", req_disp, 16'h10);
    chk("R5 addr_valid set", req_addr_valid, 1);
    step(); step();
    expect_req("R8 held", 8'd5);
    chk("R8 addr held", req_addr, 32'h1000);
    pop();
    chk("R2 drained", req_valid, 0);
  endtask

  task automatic t_hit_and_match();
    insert(0, 32'h2000, 16'h4, 8'd10, 6'd1);
    insert(0, 32'h3000, 16'h8, 8'd11, 6'd2);
    bcast(6'd1, 0);
    step(); step();
    chk("R3 hit cancels", req_valid, 0);
    bcast(6'd2, 1);
    step();
    expect_req("R4 other parent issues", 8'd11);
    chk("R4 addr", req_addr, 32'h3000);
    pop();
    step();
    chk("R3 cancelled entry never issues", req_valid, 0);
  endtask

  task automatic t_chain();
    insert(1, 32'h72, 16'h20, 8'd20, 6'd7);
    bcast(6'd7, 1);
    step();
    expect_req("R5", 8'd20);
    chk("R5 addr_valid clear", req_addr_valid, 0);
    chk("R5 parent id in addr", req_addr, 32'h72);
    pop();
  endtask

  task automatic t_full();
    for (int i = 0; i < 8; i++) insert(0, 32'h4000 + i, 16'h0, 8'(30 + i), 6'd9);
    chk("R3 R6 eight fit after cancel", drop_count, 0);
    insert(0, 32'h5000, 16'h0, 8'd38, 6'd9);
    chk("R6 ninth dropped", drop_count, 1);
    bcast(6'd9, 1);
    step();
    for (int i = 0; i < 8; i++) begin
      expect_req("R6 R7 drain", 8'(30 + i));
      pop();
    end
    chk("R6 dropped entry absent", req_valid, 0);
  endtask

  task automatic t_age();
    insert(0, 32'h50, 16'h0, 8'd50, 6'd4);
    insert(0, 32'h51, 16'h0, 8'd51, 6'd5);
    insert(0, 32'h52, 16'h0, 8'd52, 6'd4);
    bcast(6'd5, 1);
    step();
    expect_req("R7 middle first", 8'd51);
    pop();
    insert(0, 32'h53, 16'h0, 8'd53, 6'd4);
    bcast(6'd4, 1);
    step();
    expect_req("R7 oldest", 8'd50);
    pop();
    expect_req("R7 second oldest", 8'd52);
    pop();
    expect_req("R7 newest last", 8'd53);
    pop();
    chk("R7 empty", req_valid, 0);
  endtask

  task automatic t_flush();
    insert(0, 32'h60, 16'h0, 8'd60, 6'd6);
    insert(0, 32'h61, 16'h0, 8'd61, 6'd6);
    insert(0, 32'h62, 16'h0, 8'd62, 6'd6);
    bcast(6'd6, 1);
    flush_valid = 1; flush_iid = 8'd60;
    step();
    flush_valid = 0;
    expect_req("R9 older kept", 8'd60);
    pop();
    step();
    chk("R9 younger removed", req_valid, 0);
    insert(0, 32'h70, 16'h0, 8'd70, 6'd8);
    bcast(6'd8, 1);
    step();
    expect_req("R9 pending", 8'd70);
    flush_valid = 1; flush_iid = 8'd65;
    step();
    flush_valid = 0;
    chk("R9 output removed", req_valid, 0);
  endtask

  task automatic t_flush_insert();
    ins_valid = 1; ins_base_is_id = 0; ins_base = 32'h80; ins_disp = 0;
    ins_iid = 8'd80; ins_ptag = 6'd10;
    flush_valid = 1; flush_iid = 8'hFF;
    step();
    ins_valid = 0; flush_valid = 0;
    bcast(6'd10, 1);
    step(); step();
    chk("R10 insert ignored", req_valid, 0);
    chk("R10 no drop", drop_count, 1);
  endtask

  task automatic t_same_cycle();
    ins_valid = 1; ins_base_is_id = 0; ins_base = 32'h90; ins_disp = 16'h3;
    ins_iid = 8'd90; ins_ptag = 6'd12;
    res_valid = 1; res_tag = 6'd12; res_miss = 1;
    step();
    ins_valid = 0; res_valid = 0;
    step(); step();
    chk("R11 not released", req_valid, 0);
    bcast(6'd12, 1);
    step();
    expect_req("R11 later outcome", 8'd90);
    pop();
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst = 0;
    step();
    t_reset();
    t_miss();
    t_hit_and_match();
    t_chain();
    t_full();
    t_age();
    t_flush();
    t_flush_insert();
    t_same_cycle();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule